// File: doc/BRIEF.md
# E1 Transmit System-Side Frame Aligner

This block takes one 2.048 Mb/s E1 serial stream arriving from the system backplane, with the interface acting as clock slave. The shared system clock is presented to the block as a one-cycle strobe, `sys_edge`, that marks each of its active edges. The system clock runs at the bit rate or at twice the bit rate. At twice the bit rate, a configuration bit picks which of the two edges in each bit samples the data.

A common frame pulse aligns the stream. The pulse can be active high or active low. It can mark every 256-bit basic frame or only the start of each 16-frame multiframe. The block assembles the bits MSB first into timeslot bytes. Each byte is presented with a valid strobe, its timeslot number (0-31) and its frame number within the multiframe (0-15).

A shared pin works in one of two sub-modes. In signaling-input mode, a serial signaling stream is sampled on the same edges as the data and delivered as a byte beside the data byte. In framing-indication mode, the block drives a pulse that marks the start of each frame, or of each multiframe.

Top module: `e1_tx_frame_aligner`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `byte_vld`, `realign` and `fi_out` are 0. The first bit sampled after reset is bit 7 of timeslot 0 of frame 0.
- R2: With `cfg_dbl_rate`=0, every `sys_edge` samples one bit of `ser_data`. The bits form bytes MSB first. Timeslots count 0 to 31 and wrap, and the frame number then advances modulo 16.
- R3: With `cfg_dbl_rate`=1, the edges after reset alternate first and second. Data is sampled only on the first edge when `cfg_late_edge`=0, and only on the second edge when `cfg_late_edge`=1. The value on the other edge has no effect on any output.
- R4: With `cfg_dbl_rate`=1, `frame_pulse` is taken only on the first edge of a bit, whatever the value of `cfg_late_edge`. A pulse present only on the second edge has no effect.
- R5: `frame_pulse` is active high when `cfg_fp_low`=0 and active low when `cfg_fp_low`=1.
- R6: A frame pulse makes its own bit bit 7 of timeslot 0. With `cfg_fp_mf`=0, the frame number advances by one. If the pulse does not follow bit 255 of a frame, `realign` is 1 for exactly one cycle and the partial byte is dropped.
- R7: With `cfg_fp_mf`=1, a frame pulse sets the frame number to 0. `realign` rises unless the pulse follows bit 255 of frame 15.
- R8: A frame pulse that lands exactly on the expected boundary leaves `realign` at 0 and does not disturb the byte sequence.
- R9: With `cfg_ext_sig`=1, `byte_sig` carries the signaling bits sampled on the same edges as the data byte, MSB first, and `fi_out` stays 0. With `cfg_ext_sig`=0, `byte_sig` is 0. `fi_out` is 1 from the sampling of bit 7 of timeslot 0 until the next sample. With `cfg_fp_mf`=0 this happens in every frame; with `cfg_fp_mf`=1 it happens only in frame 0.
- R10: `byte_vld` is 1 for exactly one clock, in the cycle after the `sys_edge` that samples the byte's last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_edge | input | 1 | One-cycle strobe per active edge of the system clock |
| cfg_dbl_rate | input | 1 | 1: system clock is twice the bit rate |
| cfg_late_edge | input | 1 | At twice the bit rate, 1 samples data on the second edge |
| cfg_fp_low | input | 1 | 1: frame pulse is active low |
| cfg_fp_mf | input | 1 | 1: frame pulse marks multiframes |
| cfg_ext_sig | input | 1 | 1: signaling-input sub-mode; 0: framing-indication sub-mode |
| ser_data | input | 1 | Serial data, MSB of each timeslot first |
| ser_sig | input | 1 | Serial signaling bits |
| frame_pulse | input | 1 | Common frame pulse |
| byte_vld | output | 1 | Byte valid strobe |
| byte_ts | output | 5 | Timeslot number of the byte |
| byte_frm | output | 4 | Frame number within the multiframe |
| byte_data | output | 8 | Data byte |
| byte_sig | output | 8 | Signaling byte (0 in framing-indication mode) |
| realign | output | 1 | One-cycle flag for a frame pulse off the expected boundary |
| fi_out | output | 1 | Framing indication pulse |

## Verification
A bit counter that is off by even one position shows up at the next `byte_vld`. That strobe arrives at the wrong edge, or it carries a shifted byte or a wrong timeslot number, within eight bit times. A wrong frame count shows on the next `byte_frm` and on the placement of `fi_out`. A wrong boundary test shows as a wrong `realign` in the cycle right after the next frame pulse. A fault in edge selection corrupts every byte, because the bench drives the inverted bit on the edge that should not be sampled.

// File: rtl/e1ta_pkg.sv
package e1ta_pkg;
    localparam int unsigned SLOTS     = 32;
    localparam int unsigned SLOT_BITS = 8;
    localparam int unsigned MF_FRAMES = 16;

    localparam int unsigned BIT_W = $clog2(SLOT_BITS);
    localparam int unsigned TS_W  = $clog2(SLOTS);
    localparam int unsigned POS_W = BIT_W + TS_W;
    localparam int unsigned FRM_W = $clog2(MF_FRAMES);

    localparam logic [POS_W-1:0] POS_LAST = POS_W'(SLOTS * SLOT_BITS - 1);
    localparam logic [FRM_W-1:0] FRM_LAST = FRM_W'(MF_FRAMES - 1);

    typedef enum logic {
        PIN_FRAME_IND = 1'b0,
        PIN_SIG_IN    = 1'b1
    } pin_mode_e;

    typedef struct packed {
        logic [TS_W-1:0]      ts;
        logic [FRM_W-1:0]     frm;
        logic [SLOT_BITS-1:0] data;
        logic [SLOT_BITS-1:0] sig;
    } slot_t;

    function automatic logic at_boundary(input logic [POS_W-1:0] pos,
                                         input logic [FRM_W-1:0] frm,
                                         input logic             mf);
        return (pos == POS_LAST) && (!mf || (frm == FRM_LAST));
    endfunction

    function automatic logic [POS_W-1:0] pos_next(input logic [POS_W-1:0] pos);
        return (pos == POS_LAST) ? '0 : pos + 1'b1;
    endfunction
endpackage

// File: rtl/e1ta_edge_sel.sv
module e1ta_edge_sel
    import e1ta_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sys_edge,
    input  logic dbl_rate,
    input  logic late_edge,
    input  logic fp_low,
    input  logic fp_raw,
    output logic smp,
    output logic fp_hit
);
    logic phase_q;
    logic fp_pend_q;
    logic first_edge;
    logic fp_now;

    assign first_edge = !dbl_rate || !phase_q;
    assign fp_now     = fp_raw ^ fp_low;
    assign smp        = sys_edge && (!dbl_rate || (phase_q == late_edge));
    assign fp_hit     = (sys_edge && first_edge) ? fp_now : fp_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= 1'b0;
            fp_pend_q <= 1'b0;
        end else if (sys_edge) begin
            phase_q <= dbl_rate ? !phase_q : 1'b0;
            if (first_edge)
                fp_pend_q <= fp_now;
        end
    end

    // R4
    fp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sys_edge && dbl_rate && phase_q) |=> (fp_pend_q == $past(fp_pend_q)));
endmodule

// File: rtl/e1ta_bit_ctr.sv
module e1ta_bit_ctr
    import e1ta_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             smp,
    input  logic             fp_hit,
    input  logic             fp_mf,
    output logic [POS_W-1:0] pos,
    output logic [FRM_W-1:0] frm,
    output logic             realign
);
    logic on_boundary;

    assign on_boundary = at_boundary(pos, frm, fp_mf);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= POS_LAST;
            frm     <= FRM_LAST;
            realign <= 1'b0;
        end else begin
            realign <= 1'b0;
            if (smp) begin
                if (fp_hit) begin
                    pos     <= '0;
                    frm     <= fp_mf ? '0 : frm + 1'b1;
                    realign <= !on_boundary;
                end else begin
                    pos <= pos_next(pos);
                    if (pos == POS_LAST)
                        frm <= frm + 1'b1;
                end
            end
        end
    end

    // R6
    realign_pos_chk: assert property (@(posedge clk) disable iff (rst)
        realign |-> (pos == '0));

    // R7
    realign_mf_chk: assert property (@(posedge clk) disable iff (rst)
        (realign && fp_mf) |-> (frm == '0));
endmodule

// File: rtl/e1ta_byte_asm.sv
module e1ta_byte_asm
    import e1ta_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             smp,
    input  logic             ser_data,
    input  logic             ser_sig,
    input  pin_mode_e        pin_mode,
    input  logic             fp_mf,
    input  logic [POS_W-1:0] pos,
    input  logic [FRM_W-1:0] frm,
    output logic             byte_vld,
    output slot_t            slot,
    output logic             fi_out
);
    logic [SLOT_BITS-1:0] dat_sh;
    logic [SLOT_BITS-1:0] sig_sh;
    logic                 smp_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            dat_sh <= '0;
            sig_sh <= '0;
            smp_d  <= 1'b0;
        end else begin
            smp_d <= smp;
            if (smp) begin
                dat_sh <= {dat_sh[SLOT_BITS-2:0], ser_data};
                sig_sh <= {sig_sh[SLOT_BITS-2:0], ser_sig};
            end
        end
    end

    assign byte_vld = smp_d && (pos[BIT_W-1:0] == BIT_W'(SLOT_BITS - 1));

    always_comb begin
        slot.ts   = pos[POS_W-1:BIT_W];
        slot.frm  = frm;
        slot.data = dat_sh;
        slot.sig  = (pin_mode == PIN_SIG_IN) ? sig_sh : '0;
    end

    assign fi_out = (pin_mode == PIN_FRAME_IND) && (pos == '0)
                    && (!fp_mf || (frm == '0));

    // R10
    vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);

    // R9
    fi_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !smp |=> $stable(fi_out));
endmodule

// File: rtl/e1_tx_frame_aligner.sv
module e1_tx_frame_aligner
    import e1ta_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sys_edge,
    input  logic                 cfg_dbl_rate,
    input  logic                 cfg_late_edge,
    input  logic                 cfg_fp_low,
    input  logic                 cfg_fp_mf,
    input  logic                 cfg_ext_sig,
    input  logic                 ser_data,
    input  logic                 ser_sig,
    input  logic                 frame_pulse,
    output logic                 byte_vld,
    output logic [TS_W-1:0]      byte_ts,
    output logic [FRM_W-1:0]     byte_frm,
    output logic [SLOT_BITS-1:0] byte_data,
    output logic [SLOT_BITS-1:0] byte_sig,
    output logic                 realign,
    output logic                 fi_out
);
    logic             smp;
    logic             fp_hit;
    logic [POS_W-1:0] pos;
    logic [FRM_W-1:0] frm;
    slot_t            slot;
    pin_mode_e        pin_mode;

    assign pin_mode = cfg_ext_sig ? PIN_SIG_IN : PIN_FRAME_IND;

    e1ta_edge_sel u_edge (
        .clk       (clk),
        .rst       (rst),
        .sys_edge  (sys_edge),
        .dbl_rate  (cfg_dbl_rate),
        .late_edge (cfg_late_edge),
        .fp_low    (cfg_fp_low),
        .fp_raw    (frame_pulse),
        .smp       (smp),
        .fp_hit    (fp_hit)
    );

    e1ta_bit_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .smp     (smp),
        .fp_hit  (fp_hit),
        .fp_mf   (cfg_fp_mf),
        .pos     (pos),
        .frm     (frm),
        .realign (realign)
    );

    e1ta_byte_asm u_asm (
        .clk      (clk),
        .rst      (rst),
        .smp      (smp),
        .ser_data (ser_data),
        .ser_sig  (ser_sig),
        .pin_mode (pin_mode),
        .fp_mf    (cfg_fp_mf),
        .pos      (pos),
        .frm      (frm),
        .byte_vld (byte_vld),
        .slot     (slot),
        .fi_out   (fi_out)
    );

    assign byte_ts   = slot.ts;
    assign byte_frm  = slot.frm;
    assign byte_data = slot.data;
    assign byte_sig  = slot.sig;

    // R10
    vld_after_smp_chk: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> $past(smp));
endmodule

// File: tb/e1_tx_frame_aligner_tb.sv
module e1_tx_frame_aligner_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sys_edge = 1'b0;
    logic       cfg_dbl_rate = 1'b0, cfg_late_edge = 1'b0, cfg_fp_low = 1'b0;
    logic       cfg_fp_mf = 1'b0, cfg_ext_sig = 1'b0;
    logic       ser_data = 1'b0, ser_sig = 1'b0, frame_pulse = 1'b0;
    logic       byte_vld, realign, fi_out;
    logic [4:0] byte_ts;
    logic [3:0] byte_frm;
    logic [7:0] byte_data, byte_sig;

    always #4 clk = ~clk;

    e1_tx_frame_aligner u_dut (
        .clk(clk), .rst(rst), .sys_edge(sys_edge),
        .cfg_dbl_rate(cfg_dbl_rate), .cfg_late_edge(cfg_late_edge),
        .cfg_fp_low(cfg_fp_low), .cfg_fp_mf(cfg_fp_mf), .cfg_ext_sig(cfg_ext_sig),
        .ser_data(ser_data), .ser_sig(ser_sig), .frame_pulse(frame_pulse),
        .byte_vld(byte_vld), .byte_ts(byte_ts), .byte_frm(byte_frm),
        .byte_data(byte_data), .byte_sig(byte_sig), .realign(realign), .fi_out(fi_out)
    );

    // {dbl_rate, late_edge, fp_low, fp_mf, ext_sig}
    localparam logic [4:0] SCEN [6] = '{5'b00000, 5'b00101, 5'b10001,
                                        5'b11000, 5'b11111, 5'b00010};

    int          n_chk = 0, n_fail = 0;
    int          m_pos, m_frm;
    logic [7:0]  m_sh, m_ss;
    logic [15:0] lfsr = 16'hACE1;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int ex);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, ex);
        end
    endtask

    task automatic apply_reset(input logic [4:0] c);
        @(negedge clk);
        rst = 1'b1; sys_edge = 1'b0; frame_pulse = c[2];
        {cfg_dbl_rate, cfg_late_edge, cfg_fp_low, cfg_fp_mf, cfg_ext_sig} = c;
        repeat (3) @(negedge clk);
        chk(byte_vld == 0 && realign == 0 && fi_out == 0, "R1 in reset",
            {byte_vld, realign, fi_out}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(byte_vld == 0 && realign == 0 && fi_out == 0, "R1 after reset",
            {byte_vld, realign, fi_out}, 0);
        m_pos = 255; m_frm = 15; m_sh = '0; m_ss = '0;
    endtask

    task automatic drive_edge(input logic d, input logic s, input logic fpv);
        @(negedge clk);
        ser_data = d; ser_sig = s; frame_pulse = fpv ^ cfg_fp_low; sys_edge = 1'b1;
        @(negedge clk);
        sys_edge = 1'b0;
    endtask

    task automatic check_bit(input bit fp, input bit ex_re);
        string t;
        bit    ex_vld, ex_fi;
        t      = cfg_dbl_rate ? "R3" : "R2";
        ex_vld = (m_pos % 8 == 7);
        chk(byte_vld == ex_vld, t, byte_vld, ex_vld);
        if (ex_vld) begin
            chk(byte_ts == m_pos / 8, t, byte_ts, m_pos / 8);
            chk(byte_frm == m_frm, t, byte_frm, m_frm);
            chk(byte_data == m_sh, t, byte_data, m_sh);
            chk(byte_sig == (cfg_ext_sig ? m_ss : 8'h00), "R9 sig", byte_sig,
                cfg_ext_sig ? m_ss : 0);
        end
        if (fp && cfg_fp_low)  t = "R5";
        else if (cfg_fp_mf)    t = "R7";
        else if (fp && !ex_re) t = "R8";
        else                   t = "R6";
        chk(realign == ex_re, t, realign, ex_re);
        ex_fi = !cfg_ext_sig && m_pos == 0 && (!cfg_fp_mf || m_frm == 0);
        chk(fi_out == ex_fi, "R9 fi", fi_out, ex_fi);
        if (ex_vld) begin
            @(negedge clk);
            chk(byte_vld == 0, "R10", byte_vld, 0);
        end
    endtask

    task automatic send_bit(input bit fp, input bit fp_late);
        logic d, s;
        bit   ex_re;
        lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        d     = lfsr[0];
        s     = lfsr[5];
        ex_re = fp && !(m_pos == 255 && (!cfg_fp_mf || m_frm == 15));
        if (fp) begin
            m_pos = 0;
            m_frm = cfg_fp_mf ? 0 : (m_frm + 1) % 16;
        end else if (m_pos == 255) begin
            m_pos = 0;
            m_frm = (m_frm + 1) % 16;
        end else begin
            m_pos++;
        end
        m_sh = {m_sh[6:0], d};
        m_ss = {m_ss[6:0], s};
        if (!cfg_dbl_rate) begin
            drive_edge(d, s, fp);
            check_bit(fp, ex_re);
        end else if (!cfg_late_edge) begin
            drive_edge(d, s, fp);
            check_bit(fp, ex_re);
            drive_edge(~d, ~s, fp_late);
        end else begin
            drive_edge(~d, ~s, fp);
            drive_edge(d, s, fp_late);
            check_bit(fp, ex_re);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        // table walk: mid-frame pulse, two frames, then a pulse on the boundary
        for (int i = 0; i < 6; i++) begin
            apply_reset(SCEN[i]);
            repeat (20) send_bit(1'b0, 1'b0);
            send_bit(1'b1, 1'b0);
            repeat (511) send_bit(1'b0, 1'b0);
            send_bit(1'b1, 1'b0);
            repeat (30) send_bit(1'b0, 1'b0);
        end
        // R4: a pulse seen only on the second edge is ignored, both edge selections
        apply_reset(5'b11000);
        repeat (12) send_bit(1'b0, 1'b0);
        send_bit(1'b0, 1'b1);
        repeat (12) send_bit(1'b0, 1'b0);
        apply_reset(5'b10000);
        repeat (12) send_bit(1'b0, 1'b0);
        send_bit(1'b0, 1'b1);
        repeat (12) send_bit(1'b0, 1'b0);
        // R7 / R8: full multiframe, then a pulse on the expected multiframe boundary
        apply_reset(5'b00010);
        repeat (4096) send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        repeat (16) send_bit(1'b0, 1'b0);
        finish_run();
    end
endmodule